// File: doc/BRIEF.md
# SPI Transmit Data Queue with Paired-Entry Drain

This block is the transmit data queue of an SPI controller. It sits between a register-write push port and the loader of the serial shift register. Software writes 8-bit or 16-bit words into the queue. The loader asks for the next frame by raising a load request and giving the frame length in bits. Each granted request removes one or two queued entries in a single cycle.

When wide-frame mode is on and the requested frame is longer than 16 bits, the block releases two entries together. The older entry forms bits [15:0] of the frame and the newer entry forms bits [31:16]. The queue keeps a count of valid entries, and a flush input empties it at once.

Three sticky status flags are kept, each cleared by writing 1 to its bit:
- a completion flag, set at the end of every transfer;
- an underflow flag, set when an external master starts a slave-side transfer while the queue is empty;
- an overflow flag, set when a push arrives while the queue is full.

The shift register, serial clock generation and bus decode are outside this block. The loader's request and the frame length are inputs.

Top module: `txq_drain`

## Requirements
- R1: When `loadReq` is high, no paired drain is asked for and `entryCount` is at least 1, `loadGrant` is high in that cycle. `loadWord` then shows `{16'h0000, oldest entry}` in that cycle, and `entryCount` falls by one at the next edge.
- R2: A paired drain is asked for when `wideMode` is 1 and `frameBits` is greater than 16. With `loadReq` high and `entryCount` at least 2, `loadGrant` is high and `entryCount` falls by two in a single edge. With `wideMode` at 0, every frame length takes a single entry.
- R3: In a paired drain, `loadWord[15:0]` is the older of the two entries and `loadWord[31:16]` is the newer one.
- R4: A load request is stalled, with `loadGrant` low and no entry removed, when fewer entries are queued than it needs: one for a single drain, two for a paired drain.
- R5: A push with `pushByte` at 0 stores `pushData[15:0]`. A push with `pushByte` at 1 stores `{8'h00, pushData[7:0]}`. An accepted push raises `entryCount` by one, and entries leave in the order they were pushed.
- R6: `flushTx` high sets `entryCount` to 0 at the next edge. It overrides a push and a load request in the same cycle, and `loadGrant` is low while it is high.
- R7: `underflowFlag` is set at the next edge when `slaveMode` and `xferStart` are both high while `entryCount` is 0. It is not set when either input is low or when the queue holds entries.
- R8: `doneFlag` is set at the next edge after any cycle in which `xferDone` is high.
- R9: A push while `entryCount` equals the depth (4) is dropped, even if a drain happens in the same cycle. It sets `overflowFlag` and leaves the queue contents unchanged.
- R10: Writing 1 to a bit of `flagClr` clears a flag: bit 0 clears `doneFlag`, bit 1 clears `underflowFlag`, bit 2 clears `overflowFlag`. A set condition in the same cycle wins over the clear. Flags otherwise hold their value.
- R11: A push and a drain in the same cycle change `entryCount` by the net amount: +1 minus the number of entries drained.
- R12: After reset, `entryCount` is 0, all three flags are 0 and `loadGrant` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Write strobe to the queue's data half |
| pushByte | input | 1 | 1: 8-bit write (zero-extended), 0: 16-bit write |
| pushData | input | 16 | Write data |
| wideMode | input | 1 | Enables paired drain for frames over 16 bits |
| loadReq | input | 1 | Shift register loader wants the next frame |
| frameBits | input | 6 | Requested frame length in bits |
| loadGrant | output | 1 | Request accepted this cycle; entries leave at the edge |
| loadWord | output | 32 | Frame data, valid while loadGrant is high |
| flushTx | input | 1 | Empties the queue |
| slaveMode | input | 1 | Controller runs as slave |
| xferStart | input | 1 | External master begins a transfer |
| xferDone | input | 1 | A transfer has finished |
| flagClr | input | 3 | Write-1-to-clear: bit0 done, bit1 underflow, bit2 overflow |
| entryCount | output | 3 | Number of valid entries, 0 to 4 |
| doneFlag | output | 1 | Sticky transfer-complete flag |
| underflowFlag | output | 1 | Sticky slave underflow flag |
| overflowFlag | output | 1 | Sticky push-while-full flag |

## Verification
The bench targets the paired drain and its neighbouring cases:
- A paired drain at exactly one queued entry must stall. A design that grants it would read a stale slot and drive the count below zero.
- A wide frame with `wideMode` off must drain only one entry.
- Swapped halves in `loadWord` show up as a data mismatch on every paired grant.
- A push into a full queue that is being drained in the same cycle must still be dropped. A design that frees the slot first would accept it.
- A flag that is both set and cleared in one cycle must remain set.
- A flush that collides with a push or a grant must leave the queue empty.

// File: rtl/txq_pkg.sv
package txq_pkg;

  typedef struct packed {
    logic push;
    logic pop1;
    logic pop2;
    logic flush;
  } txqStrobe_t;

  localparam int unsigned FLAG_DONE  = 0;
  localparam int unsigned FLAG_UNDER = 1;
  localparam int unsigned FLAG_OVER  = 2;
  localparam int unsigned FLAG_N     = 3;

endpackage

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned FRAME_W = 6,
  parameter int unsigned NARROW  = 16,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushValid,
  input  logic               loadReq,
  input  logic [FRAME_W-1:0] frameBits,
  input  logic               wideMode,
  input  logic               flushTx,
  input  logic               slaveMode,
  input  logic               xferStart,
  input  logic               xferDone,
  input  logic [FLAG_N-1:0]  flagClr,
  output txqStrobe_t         strobe,
  output logic               loadGrant,
  output logic [CNT_W-1:0]   count,
  output logic [FLAG_N-1:0]  flags
);

  logic             pairReq;
  logic             full;
  logic             haveEnough;
  logic [CNT_W-1:0] drainAmt;
  logic [CNT_W-1:0] countNext;
  logic [FLAG_N-1:0] flagSet;

  assign pairReq    = wideMode && (frameBits > FRAME_W'(NARROW));
  assign full       = (count == CNT_W'(DEPTH));
  assign haveEnough = pairReq ? (count >= CNT_W'(2)) : (count != '0);
  assign loadGrant  = loadReq && !flushTx && haveEnough;

  always_comb begin
    strobe.flush = flushTx;
    strobe.push  = pushValid && !flushTx && !full;
    strobe.pop1  = loadGrant && !pairReq;
    strobe.pop2  = loadGrant && pairReq;
  end

  always_comb begin
    drainAmt = strobe.pop2 ? CNT_W'(2) : (strobe.pop1 ? CNT_W'(1) : '0);
    if (flushTx) countNext = '0;
    else         countNext = count + CNT_W'(strobe.push) - drainAmt;
  end

  always_comb begin
    flagSet             = '0;
    flagSet[FLAG_DONE]  = xferDone;
    flagSet[FLAG_UNDER] = slaveMode && xferStart && (count == '0);
    flagSet[FLAG_OVER]  = pushValid && !flushTx && full;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
      flags <= '0;
    end else begin
      count <= countNext;
      flags <= flagSet | (flags & ~flagClr);
    end
  end

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  p_pair_drain_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop2 && !strobe.push && !flushTx |=> count == $past(count) - CNT_W'(2));

  p_stall_short_r4: assert property (@(posedge clk) disable iff (!rstN)
    pairReq && count < CNT_W'(2) |-> !loadGrant);

  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    flushTx |=> count == '0);

  p_underflow_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode && xferStart && count == '0 |=> flags[FLAG_UNDER]);

  p_done_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> flags[FLAG_DONE]);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    pushValid && full && !flushTx && !loadGrant |=> overflowStable());

  function automatic logic overflowStable();
    return flags[FLAG_OVER] && count == CNT_W'(DEPTH);
  endfunction

  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    flagClr[FLAG_DONE] && !xferDone |=> !flags[FLAG_DONE]);

endmodule

// File: rtl/txq_data.sv
module txq_data
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned ENTRY_W = 16,
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txqStrobe_t           strobe,
  input  logic                 pushByte,
  input  logic [ENTRY_W-1:0]   pushData,
  output logic [2*ENTRY_W-1:0] loadWord
);

  logic [ENTRY_W-1:0] slot [DEPTH];
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;
  logic [PTR_W-1:0]   rdNext;
  logic [ENTRY_W-1:0] entryIn;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdNext  = step(rdPtr);
  assign entryIn = pushByte ? {{(ENTRY_W-8){1'b0}}, pushData[7:0]} : pushData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= step(wrPtr);
      if (strobe.pop2)      rdPtr <= step(rdNext);
      else if (strobe.pop1) rdPtr <= rdNext;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) slot[wrPtr] <= entryIn;
  end

  assign loadWord = strobe.pop2 ? {slot[rdNext], slot[rdPtr]}
                                : {{ENTRY_W{1'b0}}, slot[rdPtr]};

  p_flush_ptr_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flush |=> rdPtr == wrPtr);

  p_one_drain_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.pop1 && strobe.pop2));

  p_ptr_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop2 && !strobe.flush |=> rdPtr == step(step($past(rdPtr))));

endmodule

// File: rtl/txq_drain.sv
module txq_drain
  import txq_pkg::*;
#(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned ENTRY_W = 16,
  parameter int unsigned FRAME_W = 6,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pushValid,
  input  logic                 pushByte,
  input  logic [ENTRY_W-1:0]   pushData,
  input  logic                 wideMode,
  input  logic                 loadReq,
  input  logic [FRAME_W-1:0]   frameBits,
  output logic                 loadGrant,
  output logic [2*ENTRY_W-1:0] loadWord,
  input  logic                 flushTx,
  input  logic                 slaveMode,
  input  logic                 xferStart,
  input  logic                 xferDone,
  input  logic [FLAG_N-1:0]    flagClr,
  output logic [CNT_W-1:0]     entryCount,
  output logic                 doneFlag,
  output logic                 underflowFlag,
  output logic                 overflowFlag
);

  txqStrobe_t        strobe;
  logic [FLAG_N-1:0] flags;

  txq_ctrl #(
    .DEPTH  (DEPTH),
    .FRAME_W(FRAME_W),
    .NARROW (ENTRY_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .pushValid(pushValid),
    .loadReq  (loadReq),
    .frameBits(frameBits),
    .wideMode (wideMode),
    .flushTx  (flushTx),
    .slaveMode(slaveMode),
    .xferStart(xferStart),
    .xferDone (xferDone),
    .flagClr  (flagClr),
    .strobe   (strobe),
    .loadGrant(loadGrant),
    .count    (entryCount),
    .flags    (flags)
  );

  txq_data #(
    .DEPTH  (DEPTH),
    .ENTRY_W(ENTRY_W)
  ) data_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pushByte(pushByte),
    .pushData(pushData),
    .loadWord(loadWord)
  );

  assign doneFlag      = flags[FLAG_DONE];
  assign underflowFlag = flags[FLAG_UNDER];
  assign overflowFlag  = flags[FLAG_OVER];

endmodule

// File: tb/txq_drain_tb_top.sv
`timescale 1ns/100ps
module txq_drain_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushValid = 0, pushByte = 0, wideMode = 0, loadReq = 0;
  logic [15:0] pushData = '0;
  logic [5:0]  frameBits = '0;
  logic        flushTx = 0, slaveMode = 0, xferStart = 0, xferDone = 0;
  logic [2:0]  flagClr = '0;
  logic        loadGrant, doneFlag, underflowFlag, overflowFlag;
  logic [31:0] loadWord;
  logic [2:0]  entryCount;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 0;

  logic [15:0] m [4];
  int          mCnt = 0;
  logic        eDone = 0, eUnder = 0, eOver = 0;
  string       cntTag = "R12";
  logic [2:0]  lastClr = '0;

  always #2.5 clk = ~clk;

  txq_drain dut_i (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushByte(pushByte),
    .pushData(pushData), .wideMode(wideMode), .loadReq(loadReq),
    .frameBits(frameBits), .loadGrant(loadGrant), .loadWord(loadWord),
    .flushTx(flushTx), .slaveMode(slaveMode), .xferStart(xferStart),
    .xferDone(xferDone), .flagClr(flagClr), .entryCount(entryCount),
    .doneFlag(doneFlag), .underflowFlag(underflowFlag), .overflowFlag(overflowFlag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkRegs();
    chk(cntTag, 32'(entryCount), 32'(mCnt));
    chk(lastClr[0] ? "R10 done" : "R8 done", 32'(doneFlag), 32'(eDone));
    chk(lastClr[1] ? "R10 underflow" : "R7 underflow", 32'(underflowFlag), 32'(eUnder));
    chk(lastClr[2] ? "R10 overflow" : "R9 overflow", 32'(overflowFlag), 32'(eOver));
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    loadReq = 1'b1;
    #1;
    chk("R12 grant", 32'(loadGrant), 32'd0);
    chk("R12 count", 32'(entryCount), 32'd0);
    chk("R12 flags", {29'd0, overflowFlag, underflowFlag, doneFlag}, 32'd0);
    loadReq = 1'b0;

    for (int cyc = 0; cyc < 4000; cyc++) begin
      bit twoP, grantE, doPush;
      int need, preCnt, n;
      logic [15:0] entry;
      @(negedge clk);
      checkRegs();
      pushValid = ($urandom % 2) == 0;
      pushByte  = ($urandom % 3) == 0;
      pushData  = 16'($urandom);
      wideMode  = ($urandom % 2) == 0;
      loadReq   = ($urandom % 2) == 0;
      frameBits = 6'($urandom % 33);
      flushTx   = ($urandom % 16) == 0;
      slaveMode = ($urandom % 2) == 0;
      xferStart = ($urandom % 3) == 0;
      xferDone  = ($urandom % 5) == 0;
      flagClr   = {($urandom % 6) == 0, ($urandom % 6) == 0, ($urandom % 6) == 0};
      #1;
      twoP   = wideMode && (frameBits > 6'd16);
      need   = twoP ? 2 : 1;
      grantE = loadReq && !flushTx && (mCnt >= need);
      chk(!grantE ? "R4 stall" : (twoP ? "R2 grant" : "R1 grant"),
          32'(loadGrant), 32'(grantE));
      if (grantE)
        chk(twoP ? "R3 word" : "R5 word", loadWord,
            twoP ? {m[1], m[0]} : {16'h0000, m[0]});
      preCnt = mCnt;
      doPush = pushValid && !flushTx;
      entry  = pushByte ? {8'h00, pushData[7:0]} : pushData;
      eDone  = xferDone | (eDone & ~flagClr[0]);
      eUnder = (slaveMode && xferStart && preCnt == 0) | (eUnder & ~flagClr[1]);
      eOver  = (doPush && preCnt == 4) | (eOver & ~flagClr[2]);
      lastClr = flagClr;
      if (flushTx) begin
        mCnt = 0;
        cntTag = "R6 flush";
      end else begin
        n = grantE ? need : 0;
        for (int k = 0; k < 4; k++) m[k] = (k + n < 4) ? m[k + n] : 16'hxxxx;
        mCnt = mCnt - n;
        if (doPush && preCnt < 4) begin
          m[mCnt] = entry;
          mCnt++;
        end
        if (doPush && preCnt == 4) cntTag = "R9 count";
        else if (doPush && n > 0)  cntTag = "R11 net";
        else if (doPush)           cntTag = "R5 count";
        else if (n == 2)           cntTag = "R2 count";
        else                       cntTag = "R1 count";
      end
    end
    @(negedge clk);
    checkRegs();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule